// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine with Fault Stop

This block runs one memory-to-memory copy at a time. A start pulse loads a descriptor: a source address, a destination address, a signed step for each side, and an iteration count. For each iteration the engine reads one beat from the source and writes that beat to the destination. Both addresses then move by their steps, and one iteration is counted off.

Reads and writes overlap: the next read may be in flight while the previous write is still waiting for its response. The bus has no ready signal and accepts every request in the cycle it is presented. Responses return in order, one per request, at least one cycle later.

When the bus flags an error, the engine stops issuing new work. It lets the transfer already behind the faulting access finish, and the two directions are handled differently. The engine then reports the point it reached through a one-cycle descriptor write-back, together with a cause strobe. Finally it drops back to idle, ready to serve the next channel.

Top module: `dma_xfer_engine`

## Requirements
- R1: Iteration k (counting from 0) reads address S+k·SO and writes the returned beat to D+k·DO. SO and DO are two's-complement values of OFS_W bits, sign-extended to the address width, and all address arithmetic wraps modulo 2^ADDR_W.
- R2: At most one read and at most one write are outstanding at any time. A new read is issued only when the previous read's beat has been handed to a write.
- R3: On error-free completion, `wb_valid` and `done` are high for one cycle. This is the cycle after the response to the final write. In that cycle `wb_src` = S+N·SO, `wb_dst` = D+N·DO and `wb_count` = 0, and `irq` is high as well when `cfg_irq_en` was 1 at start.
- R4: A start with a count of 0 issues no bus request. It gives `wb_valid` and `done` in the cycle after the start pulse, with `wb_src` = S, `wb_dst` = D and `wb_count` = 0.
- R5: A read error on iteration k stops all further reads. The write of iteration k is still issued and carries the data returned with the errored response. Termination raises `src_err`.
- R6: A write error on iteration k means no write after it is ever issued. When k+1 < N, the read of iteration k+1 is still issued and answered before termination. No read beyond it is issued. Termination raises `dst_err`.
- R7: On an error at iteration k, the write-back gives `wb_src` = S+k·SO, `wb_dst` = D+k·DO and `wb_count` = N−k.
- R8: An error termination keeps `done` and `irq` low. Its `wb_valid` comes in the cycle after the last response of the drained transfers.
- R9: A start pulse while `busy` is high is ignored. `busy` falls in the cycle after `wb_valid`, and a new start is then accepted.
- R10: After reset, `busy`, `rd_req`, `wr_req`, `wb_valid`, `done`, `irq`, `src_err` and `dst_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load descriptor and begin when idle |
| cfg_src | input | ADDR_W | First source address |
| cfg_dst | input | ADDR_W | First destination address |
| cfg_soff | input | OFS_W | Signed source step |
| cfg_doff | input | OFS_W | Signed destination step |
| cfg_count | input | CNT_W | Number of iterations |
| cfg_irq_en | input | 1 | Raise irq on error-free completion |
| busy | output | 1 | A copy is in progress |
| rd_req | output | 1 | Read request, accepted in the cycle shown |
| rd_addr | output | ADDR_W | Read address |
| rd_resp | input | 1 | Read response strobe |
| rd_data | input | DATA_W | Read data |
| rd_err | input | 1 | Read response carries an error |
| wr_req | output | 1 | Write request, accepted in the cycle shown |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_resp | input | 1 | Write response strobe |
| wr_err | input | 1 | Write response carries an error |
| wb_valid | output | 1 | Descriptor write-back strobe |
| wb_src | output | ADDR_W | Written-back source address |
| wb_dst | output | ADDR_W | Written-back destination address |
| wb_count | output | CNT_W | Written-back remaining iterations |
| done | output | 1 | Error-free completion strobe |
| irq | output | 1 | Completion interrupt strobe |
| src_err | output | 1 | Termination by read error |
| dst_err | output | 1 | Termination by write error |

## Verification
A request is due in the cycle the engine presents it. The bench's bus model samples each request in the middle of that cycle and checks its address and data there, against values computed from the descriptor and the iteration index. The write-back, with its cause strobes, is due exactly one cycle after the final bus response, or one cycle after the start pulse when the count is zero. The bench stamps the cycle of every response it drives and compares the cycle in which it first sees `wb_valid` against that stamp plus one. `busy` is then checked low one cycle later. Read and write totals per run are compared with the counts that each error position implies.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

   // Why a copy came to an end; decoded into the output strobes.
   typedef enum logic [1:0] {
      END_NONE = 2'd0,
      END_OK   = 2'd1,
      END_SRC  = 2'd2,
      END_DST  = 2'd3
   } end_cause_e;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int ADDR_W     = 32,
   parameter int OFS_W      = 16,
   parameter bit SIGNED_OFS = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] next
);
   localparam int PAD_W = ADDR_W - OFS_W;

   if (OFS_W > ADDR_W) begin : g_bad_width
      $error("dma_addr_step: OFS_W must not exceed ADDR_W");
   end

   logic [ADDR_W-1:0] ofs_ext;

   if (PAD_W == 0) begin : g_no_pad
      assign ofs_ext = ofs;
   end else if (SIGNED_OFS) begin : g_sext
      assign ofs_ext = {{PAD_W{ofs[OFS_W-1]}}, ofs};
   end else begin : g_zext
      assign ofs_ext = {{PAD_W{1'b0}}, ofs};
   end

   assign next = base + ofs_ext;
endmodule

// File: rtl/dma_rd_stage.sv
module dma_rd_stage #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              issue,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [CNT_W-1:0]  issue_rem,
   input  logic              resp,
   input  logic [DATA_W-1:0] resp_data,
   input  logic              take,
   output logic              pending,
   output logic [ADDR_W-1:0] pend_addr,
   output logic [CNT_W-1:0]  pend_rem,
   output logic              full,
   output logic [DATA_W-1:0] beat_data,
   output logic [ADDR_W-1:0] beat_src,
   output logic [CNT_W-1:0]  beat_rem
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending   <= 1'b0;
         pend_addr <= '0;
         pend_rem  <= '0;
         full      <= 1'b0;
         beat_data <= '0;
         beat_src  <= '0;
         beat_rem  <= '0;
      end else if (flush) begin
         pending <= 1'b0;
         full    <= 1'b0;
      end else begin
         if (issue) begin
            pending   <= 1'b1;
            pend_addr <= issue_addr;
            pend_rem  <= issue_rem;
         end else if (resp) begin
            pending <= 1'b0;
         end
         // Data is captured even when the response reports an error.
         if (resp) begin
            full      <= 1'b1;
            beat_data <= resp_data;
            beat_src  <= pend_addr;
            beat_rem  <= pend_rem;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end

   // R2: a beat never lands on a buffer that still holds one
   a_r2_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      resp |-> !full);
   // R2: a read response always belongs to an outstanding read
   a_r2_resp_matched: assert property (@(posedge clk) disable iff (!rst_n)
      resp |-> pending);
endmodule

// File: rtl/dma_wr_stage.sv
module dma_wr_stage #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              issue,
   input  logic [ADDR_W-1:0] issue_src,
   input  logic [ADDR_W-1:0] issue_dst,
   input  logic [CNT_W-1:0]  issue_rem,
   input  logic              resp,
   output logic              pending,
   output logic [ADDR_W-1:0] pend_src,
   output logic [ADDR_W-1:0] pend_dst,
   output logic [CNT_W-1:0]  pend_rem
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         pend_src <= '0;
         pend_dst <= '0;
         pend_rem <= '0;
      end else if (flush) begin
         pending <= 1'b0;
      end else if (issue) begin
         pending  <= 1'b1;
         pend_src <= issue_src;
         pend_dst <= issue_dst;
         pend_rem <= issue_rem;
      end else if (resp) begin
         pending <= 1'b0;
      end
   end

   // R2: a second write is never issued over an outstanding one
   a_r2_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !pending);
   // R2: a write response always belongs to an outstanding write
   a_r2_wresp_matched: assert property (@(posedge clk) disable iff (!rst_n)
      resp |-> pending);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_xfer_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int OFS_W      = 16,
   parameter int CNT_W      = 16,
   parameter bit SIGNED_OFS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_src,
   input  logic [ADDR_W-1:0] cfg_dst,
   input  logic [OFS_W-1:0]  cfg_soff,
   input  logic [OFS_W-1:0]  cfg_doff,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              cfg_irq_en,
   output logic              busy,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_resp,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_resp,
   input  logic              wr_err,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_src,
   output logic [ADDR_W-1:0] wb_dst,
   output logic [CNT_W-1:0]  wb_count,
   output logic              done,
   output logic              irq,
   output logic              src_err,
   output logic              dst_err
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (OFS_W < 1 || OFS_W > ADDR_W) begin : g_bad_ofs
      $error("dma_xfer_engine: OFS_W must lie in 1..ADDR_W");
   end
   if (CNT_W < 1 || DATA_W < 1) begin : g_bad_cnt
      $error("dma_xfer_engine: CNT_W and DATA_W must be positive");
   end

   // Channel state
   logic              active;
   logic              flt_src_q, flt_dst_q, irq_en_q;
   logic [ADDR_W-1:0] rd_next, wr_next;
   logic [OFS_W-1:0]  soff_q, doff_q;
   logic [CNT_W-1:0]  rd_left, wr_left;
   logic [ADDR_W-1:0] flt_src_addr, flt_dst_addr;
   logic [CNT_W-1:0]  flt_cnt;

   // Stage outputs
   logic              rd_pend, beat_full;
   logic [ADDR_W-1:0] rd_pend_addr, beat_src;
   logic [CNT_W-1:0]  rd_pend_rem, beat_rem;
   logic [DATA_W-1:0] beat_data;
   logic              wr_pend;
   logic [ADDR_W-1:0] wr_pend_src, wr_pend_dst;
   logic [CNT_W-1:0]  wr_pend_rem;

   logic [ADDR_W-1:0] src_stepped, dst_stepped;
   logic              flt_any, rd_go, wr_go, finish, dst_hit, src_hit;
   end_cause_e        cause;

   assign flt_any = flt_src_q | flt_dst_q;
   assign rd_go   = active & ~flt_any & ~rd_pend & ~beat_full & (rd_left != '0);
   assign wr_go   = active & ~flt_dst_q & beat_full & ~wr_pend;
   // Write errors rank first: that write belongs to an older iteration.
   assign dst_hit = active & wr_resp & wr_err & ~flt_any;
   assign src_hit = active & rd_resp & rd_err & ~flt_any & ~dst_hit;

   always_comb begin
      cause = END_NONE;
      if (active && !rd_pend && !wr_pend) begin
         if (flt_dst_q)                     cause = END_DST;
         else if (flt_src_q && !beat_full)  cause = END_SRC;
         else if (!flt_any && wr_left == '0) cause = END_OK;
      end
   end
   assign finish = (cause != END_NONE);

   dma_addr_step #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SIGNED_OFS(SIGNED_OFS)) u_src_step (
      .base(rd_next), .ofs(soff_q), .next(src_stepped));
   dma_addr_step #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SIGNED_OFS(SIGNED_OFS)) u_dst_step (
      .base(wr_next), .ofs(doff_q), .next(dst_stepped));

   dma_rd_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .flush(finish),
      .issue(rd_go), .issue_addr(rd_next), .issue_rem(rd_left),
      .resp(rd_resp), .resp_data(rd_data), .take(wr_go),
      .pending(rd_pend), .pend_addr(rd_pend_addr), .pend_rem(rd_pend_rem),
      .full(beat_full), .beat_data(beat_data), .beat_src(beat_src), .beat_rem(beat_rem));

   dma_wr_stage #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .flush(finish),
      .issue(wr_go), .issue_src(beat_src), .issue_dst(wr_next), .issue_rem(beat_rem),
      .resp(wr_resp),
      .pending(wr_pend), .pend_src(wr_pend_src), .pend_dst(wr_pend_dst), .pend_rem(wr_pend_rem));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active       <= 1'b0;
         flt_src_q    <= 1'b0;
         flt_dst_q    <= 1'b0;
         irq_en_q     <= 1'b0;
         rd_next      <= '0;
         wr_next      <= '0;
         soff_q       <= '0;
         doff_q       <= '0;
         rd_left      <= '0;
         wr_left      <= '0;
         flt_src_addr <= '0;
         flt_dst_addr <= '0;
         flt_cnt      <= '0;
      end else if (!active) begin
         if (start) begin
            active    <= 1'b1;
            flt_src_q <= 1'b0;
            flt_dst_q <= 1'b0;
            irq_en_q  <= cfg_irq_en;
            rd_next   <= cfg_src;
            wr_next   <= cfg_dst;
            soff_q    <= cfg_soff;
            doff_q    <= cfg_doff;
            rd_left   <= cfg_count;
            wr_left   <= cfg_count;
         end
      end else if (finish) begin
         active    <= 1'b0;
         flt_src_q <= 1'b0;
         flt_dst_q <= 1'b0;
      end else begin
         if (rd_go) begin
            rd_next <= src_stepped;
            rd_left <= rd_left - CNT_ONE;
         end
         if (wr_go) begin
            wr_next <= dst_stepped;
         end
         if (wr_resp && !wr_err) begin
            wr_left <= wr_left - CNT_ONE;
         end
         if (dst_hit) begin
            flt_dst_q    <= 1'b1;
            flt_src_addr <= wr_pend_src;
            flt_dst_addr <= wr_pend_dst;
            flt_cnt      <= wr_pend_rem;
         end else if (src_hit) begin
            // Write k has not issued yet, so wr_next is still D+k*DO.
            flt_src_q    <= 1'b1;
            flt_src_addr <= rd_pend_addr;
            flt_dst_addr <= wr_next;
            flt_cnt      <= rd_pend_rem;
         end
      end
   end

   assign busy     = active;
   assign rd_req   = rd_go;
   assign rd_addr  = rd_next;
   assign wr_req   = wr_go;
   assign wr_addr  = wr_next;
   assign wr_data  = beat_data;
   assign wb_valid = finish;
   assign wb_src   = flt_any ? flt_src_addr : rd_next;
   assign wb_dst   = flt_any ? flt_dst_addr : wr_next;
   assign wb_count = flt_any ? flt_cnt : '0;
   assign done     = (cause == END_OK);
   assign irq      = (cause == END_OK) & irq_en_q;
   assign src_err  = (cause == END_SRC);
   assign dst_err  = (cause == END_DST);

   // R2: no second read while one is outstanding
   a_r2_one_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pend |-> !rd_req);
   // R5: a read error shuts off further reads
   a_r5_no_read_after_src: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_resp && rd_err) |=> !rd_req);
   // R6: a write error shuts off further writes
   a_r6_no_write_after_dst: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_resp && wr_err) |=> !wr_req);
   // R8: error endings never report completion
   a_r8_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      (src_err || dst_err) |-> (!done && !irq && wb_valid));
   // R9: busy drops right after the write-back
   a_r9_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !busy);
   // R10: an idle engine drives no traffic
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req && !wr_req && !wb_valid));
endmodule

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int OW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
   logic [OW-1:0] cfg_soff = '0, cfg_doff = '0;
   logic [CW-1:0] cfg_count = '0;
   logic          cfg_irq_en = 1'b0;
   logic          busy, rd_req, wr_req, wb_valid, done, irq, src_err, dst_err;
   logic [AW-1:0] rd_addr, wr_addr, wb_src, wb_dst;
   logic [DW-1:0] wr_data;
   logic [CW-1:0] wb_count;
   logic          rd_resp = 1'b0, rd_err = 1'b0, wr_resp = 1'b0, wr_err = 1'b0;
   logic [DW-1:0] rd_data = '0;

   int unsigned n_chk = 0, n_fail = 0;
   int unsigned cyc = 0;

   // Current run, shared with the bus model
   logic [AW-1:0] e_s, e_d, e_so, e_do;
   int            e_n, e_kind, e_idx;
   int            n_rd, n_wr, last_resp;

   dma_xfer_engine u_dma_xfer_engine (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_soff(cfg_soff), .cfg_doff(cfg_doff),
      .cfg_count(cfg_count), .cfg_irq_en(cfg_irq_en), .busy(busy),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_resp(rd_resp), .rd_data(rd_data), .rd_err(rd_err),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_resp(wr_resp), .wr_err(wr_err),
      .wb_valid(wb_valid), .wb_src(wb_src), .wb_dst(wb_dst), .wb_count(wb_count),
      .done(done), .irq(irq), .src_err(src_err), .dst_err(dst_err));

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
      return (a * 32'h0001_0003) ^ 32'hC3A5_1E0F;
   endfunction

   function automatic logic [AW-1:0] sext(input logic [OW-1:0] o);
      return {{(AW-OW){o[OW-1]}}, o};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Bus model: sees requests mid-cycle, answers after 1..3 cycles.
   initial begin
      int rd_wait = 0, wr_wait = 0, rd_idx = 0, wr_idx = 0;
      bit rd_busy = 0, wr_busy = 0;
      logic [AW-1:0] rd_a = '0;
      forever begin
         @(negedge clk);
         rd_resp = 1'b0; rd_err = 1'b0; wr_resp = 1'b0; wr_err = 1'b0;
         if (rd_busy) begin
            rd_wait--;
            if (rd_wait == 0) begin
               rd_resp = 1'b1;
               rd_data = mem_word(rd_a);
               rd_err  = (e_kind == 1 && rd_idx == e_idx);
               rd_busy = 0;
               last_resp = int'(cyc);
            end
         end
         if (wr_busy) begin
            wr_wait--;
            if (wr_wait == 0) begin
               wr_resp = 1'b1;
               wr_err  = (e_kind == 2 && wr_idx == e_idx);
               wr_busy = 0;
               last_resp = int'(cyc);
            end
         end
         if (rd_req) begin
            // R2: only one read in flight; R1: address of iteration n_rd
            chk(!rd_busy, "R2 read overlap", 64'(rd_busy), 64'd0);
            chk(rd_addr == e_s + AW'(n_rd) * e_so, "R1 read addr", 64'(rd_addr),
                64'(e_s + AW'(n_rd) * e_so));
            rd_a = rd_addr; rd_idx = n_rd; n_rd++;
            rd_busy = 1; rd_wait = 1 + int'($urandom_range(2));
         end
         if (wr_req) begin
            chk(!wr_busy, "R2 write overlap", 64'(wr_busy), 64'd0);
            chk(wr_addr == e_d + AW'(n_wr) * e_do, "R1 write addr", 64'(wr_addr),
                64'(e_d + AW'(n_wr) * e_do));
            // R1/R5: data is the beat read for this iteration, errored or not
            chk(wr_data == mem_word(e_s + AW'(n_wr) * e_so), "R1 R5 write data", 64'(wr_data),
                64'(mem_word(e_s + AW'(n_wr) * e_so)));
            wr_idx = n_wr; n_wr++;
            wr_busy = 1; wr_wait = 1 + int'($urandom_range(2));
         end
      end
   end

   task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input logic [OW-1:0] so, input logic [OW-1:0] dof,
                      input int n, input bit ien, input int kind, input int idx,
                      input bit poke);
      int st_cyc, k, exp_rd, exp_wr, waited;
      bit seen;
      logic [AW-1:0] xs, xd;
      logic [CW-1:0] xc;
      e_s = s; e_d = d; e_so = sext(so); e_do = sext(dof);
      e_n = n; e_kind = kind; e_idx = idx;
      n_rd = 0; n_wr = 0; last_resp = -10;
      @(negedge clk);
      start = 1'b1; cfg_src = s; cfg_dst = d; cfg_soff = so; cfg_doff = dof;
      cfg_count = CW'(n); cfg_irq_en = ien;
      st_cyc = int'(cyc);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R9: a start while busy must change nothing
         start = 1'b1; cfg_src = ~s; cfg_dst = ~d; cfg_soff = so + 16'd4; cfg_count = CW'(n + 3);
         @(negedge clk);
         start = 1'b0;
      end
      seen = 0; waited = 0;
      while (!seen && waited < 3000) begin
         if (wb_valid) seen = 1;
         else begin @(negedge clk); waited++; end
      end
      chk(seen, "R3 R8 write-back timeout", 64'(seen), 64'd1);
      if (!seen) return;
      k = (kind == 0) ? n : idx;
      xs = s + AW'(k) * sext(so);
      xd = d + AW'(k) * sext(dof);
      xc = (kind == 0) ? '0 : CW'(n - idx);
      chk(wb_src == xs, "R3 R7 wb_src", 64'(wb_src), 64'(xs));
      chk(wb_dst == xd, "R3 R7 wb_dst", 64'(wb_dst), 64'(xd));
      chk(wb_count == xc, "R3 R7 wb_count", 64'(wb_count), 64'(xc));
      chk(done == (kind == 0), "R3 R8 done", 64'(done), 64'(kind == 0));
      chk(irq == (kind == 0 && ien), "R3 R8 irq", 64'(irq), 64'(kind == 0 && ien));
      chk(src_err == (kind == 1), "R5 src_err", 64'(src_err), 64'(kind == 1));
      chk(dst_err == (kind == 2), "R6 dst_err", 64'(dst_err), 64'(kind == 2));
      if (n == 0)
         chk(int'(cyc) == st_cyc + 1, "R4 zero-count timing", 64'(cyc), 64'(st_cyc + 1));
      else
         chk(int'(cyc) == last_resp + 1, "R3 R8 write-back cycle", 64'(cyc), 64'(last_resp + 1));
      exp_rd = (kind == 0) ? n : (kind == 1) ? idx + 1 : ((idx + 2 < n) ? idx + 2 : n);
      exp_wr = (kind == 0) ? n : idx + 1;
      chk(n_rd == exp_rd, "R4 R5 R6 read total", 64'(n_rd), 64'(exp_rd));
      chk(n_wr == exp_wr, "R5 R6 write total", 64'(n_wr), 64'(exp_wr));
      @(negedge clk);
      chk(!busy && !wb_valid, "R9 idle after write-back", 64'({busy, wb_valid}), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240517));
      e_s = '0; e_d = '0; e_so = '0; e_do = '0; e_n = 0; e_kind = 0; e_idx = 0;
      n_rd = 0; n_wr = 0; last_resp = -10;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk({busy, rd_req, wr_req, wb_valid, done, irq, src_err, dst_err} == 8'd0,
          "R10 reset outputs", 64'({busy, rd_req, wr_req, wb_valid, done, irq, src_err, dst_err}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run(32'h1000, 32'h8000, 16'd4, 16'd4, 6, 1'b1, 0, 0, 1'b0);    // R3 plain copy
      run(32'h2000, 32'h9000, 16'hFFFC, 16'd8, 5, 1'b0, 0, 0, 1'b1); // R1 negative step, R9 poke
      run(32'h3000, 32'hA000, 16'd4, 16'd4, 0, 1'b1, 0, 0, 1'b0);    // R4 zero count
      run(32'h4000, 32'hB000, 16'd4, 16'd4, 4, 1'b1, 1, 0, 1'b0);    // R5 first read
      run(32'h4100, 32'hB100, 16'd4, 16'd4, 4, 1'b1, 1, 3, 1'b0);    // R5 last read
      run(32'h5000, 32'hC000, 16'd4, 16'hFFF0, 4, 1'b1, 2, 0, 1'b0); // R6 first write
      run(32'h5100, 32'hC100, 16'd4, 16'd4, 4, 1'b1, 2, 3, 1'b0);    // R6 last write
      run(32'hFFFF_FFF8, 32'h10, 16'd4, 16'd4, 4, 1'b0, 0, 0, 1'b0); // R1 wrap

      for (int t = 0; t < 60; t++) begin
         int n, kind, idx;
         n = int'($urandom_range(10));
         kind = (n == 0) ? 0 : int'($urandom_range(2));
         idx = (n == 0) ? 0 : int'($urandom_range(n - 1));
         run($urandom, $urandom, OW'($urandom_range(64)) - 16'd32, OW'($urandom_range(64)) - 16'd32,
             n, 1'($urandom), kind, idx, (t % 5) == 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule